// File: doc/BRIEF.md
# Descriptor-ring audio DMA channel

This block is a single bus-master channel for an audio controller. Software places up to 32 buffer descriptors in system memory, writes the ring base address, and tells the channel which entry is the last valid one. Once started, the channel reads each 8-byte descriptor with two 32-bit memory reads. It then offers one 16-bit sample slot per handshake on a stream port, at a word address that steps by two bytes. It counts the remaining samples down and moves through the ring until it reaches the last valid entry, where it halts.

Status flags report halting, a completed buffer, completion of the last valid buffer, and FIFO errors. The three interrupt flags are cleared by writing ones, and they drive a level interrupt through per-flag enables. Software can extend a halted but still enabled ring by writing a new last-valid index, which restarts the channel at the next entry. A register write cycle has priority over the engine: while a write is present the engine stays where it is and no sample is offered.

Top module: `desc_ring_chan`

## Requirements
- R1: After reset the status register reads 0x01 (halted only), the index register, count, base and control read 0, `irq` is low and no memory read is requested.
- R2: The register map is 0 ring base, 1 indices, 2 status, 3 control, 4 remaining count (read only). A write to address 0 stores the base with bits 1:0 forced to zero.
- R3: The ring has 32 entries. Every advance copies the prefetch index into the current index and increments the prefetch index modulo 32. Index register reads are {8'h0, prefetch, last-valid, current}, one byte each. Writing control with bit 0 (run) set advances the ring, clears halted (status bit 0) and starts a fetch at base + current*8.
- R4: A descriptor's word 0 (at +0) is the buffer address with bits 1:0 forced to zero. Word 1 (at +4) holds the sample count in bits 15:0 and the completion-interrupt flag in bit 31. No sample is offered while a descriptor read is in progress. Each accepted sample decrements the count by one and steps `smp_addr` by 2.
- R5: When the count reaches zero, status bit 3 is set if the descriptor's completion flag was set. Status bit 1 is then cleared, and if the current index differs from the last-valid index the ring advances and the next descriptor is fetched.
- R6: If the current index equals the last-valid index when the count reaches zero, status bits 2, 1 and 0 are set and no further sample is offered.
- R7: A descriptor of length zero is skipped by advancing the ring. If the current index already equals the last-valid index, the channel instead halts (status 0x01 with no interrupt flag set).
- R8: A write to address 1 stores bits 4:0 as the last-valid index. If run is set and the channel is halted, the write first clears status bits 1 and 0, advances the ring and starts a fetch. Otherwise it has no other effect.
- R9: Writing control with run clear sets halted and stops memory requests and sample offers.
- R10: Writing control with bit 1 set resets the channel: base, all indices and count become zero, status becomes 0x01, and control keeps only its bits 4:2.
- R11: Writing ones to status bits 4:2 clears them. Status bits 1:0 ignore writes.
- R12: Interrupt enables are control bit 2 (status bit 2), bit 4 (status bit 3) and bit 3 (status bit 4). When the flag field (status bits 4:2) changes to a nonzero value holding an enabled flag, `irq` goes high. When the field becomes zero, `irq` goes low. Otherwise `irq` holds.
- R13: A cycle with `fifo_err` high sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Descriptor word read request, held until answered |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| smp_valid | output | 1 | A sample slot is offered |
| smp_ready | input | 1 | Sample slot accepted |
| smp_addr | output | 32 | Memory address of the offered sample |
| fifo_err | input | 1 | FIFO error event |
| irq | output | 1 | Level interrupt |

## Verification
Embedded properties check on every cycle that the flag and interrupt states stay consistent: no interrupt without a flag, the interrupt drops with the last flag, and current-equals-last only rises together with halted. They also check that a halted channel never requests memory or offers a sample, that each accepted sample lowers the count by exactly one, and that sample addresses stay even. Only the bench's scenarios can show the ring order across a skipped empty entry, the restart by a last-valid write, the mixed clear-on-write and read-only status bits, and the selective effect of channel reset on control. The bench checks these against a scoreboard of expected sample addresses and explicit register reads.

// File: rtl/desc_ring_chan.sv
module desc_ring_chan #(
  parameter int AW = 32,
  parameter int IW = 5,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          smp_valid,
  input  logic          smp_ready,
  output logic [AW-1:0] smp_addr,
  input  logic          fifo_err,
  output logic          irq
);
  localparam logic [2:0] A_BASE = 3'd0, A_IDX = 3'd1, A_STAT = 3'd2, A_CTRL = 3'd3, A_CNT = 3'd4;
  localparam int PADW = 8 - IW;

  typedef enum logic [1:0] {S_IDLE, S_F0, S_F1, S_XF} st_t;

  st_t           st_q, n_st;
  logic [AW-1:0] base_q, n_base, buf_q, n_buf;
  logic [IW-1:0] cur_q, n_cur, last_q, n_last, pre_q, n_pre;
  logic [CW-1:0] cnt_q, n_cnt;
  logic [4:0]    ctrl_q, n_ctrl;
  logic [2:0]    ist_q, n_ist, iset, iclr, ien;
  logic          halt_q, n_halt, celv_q, n_celv, ioc_q, n_ioc, irq_q, n_irq, adv;

  logic unused_bits;
  assign unused_bits = ^mem_rdata[1:0];

  assign mem_req   = (st_q == S_F0) || (st_q == S_F1);
  assign mem_addr  = base_q + AW'({cur_q, 3'b000}) + ((st_q == S_F1) ? AW'(4) : AW'(0));
  assign smp_valid = (st_q == S_XF) && (cnt_q != '0) && !reg_wr;
  assign smp_addr  = buf_q;
  assign irq       = irq_q;
  assign ien       = {ctrl_q[3], ctrl_q[4], ctrl_q[2]};

  always_comb begin
    case (reg_addr)
      A_BASE:  reg_rdata = 32'(base_q);
      A_IDX:   reg_rdata = {8'h00, {PADW{1'b0}}, pre_q, {PADW{1'b0}}, last_q, {PADW{1'b0}}, cur_q};
      A_STAT:  reg_rdata = {27'd0, ist_q, celv_q, halt_q};
      A_CTRL:  reg_rdata = {27'd0, ctrl_q};
      A_CNT:   reg_rdata = 32'(cnt_q);
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    n_st = st_q; n_base = base_q; n_buf = buf_q; n_cur = cur_q; n_last = last_q;
    n_pre = pre_q; n_cnt = cnt_q; n_ctrl = ctrl_q; n_halt = halt_q; n_celv = celv_q;
    n_ioc = ioc_q; iset = '0; iclr = '0; adv = 1'b0;
    if (reg_wr) begin
      case (reg_addr)
        A_BASE: n_base = {reg_wdata[AW-1:2], 2'b00};
        A_IDX: begin
          if (ctrl_q[0] && halt_q) begin
            n_halt = 1'b0; n_celv = 1'b0; adv = 1'b1;
          end
          n_last = reg_wdata[IW-1:0];
        end
        A_STAT: iclr = reg_wdata[4:2];
        A_CTRL: begin
          if (reg_wdata[1]) begin
            n_base = '0; n_cur = '0; n_last = '0; n_pre = '0; n_cnt = '0;
            n_halt = 1'b1; n_celv = 1'b0; iclr = '1; n_st = S_IDLE;
            n_ctrl = ctrl_q & 5'b11100;
          end else begin
            n_ctrl = reg_wdata[4:0];
            if (!reg_wdata[0]) begin
              n_halt = 1'b1; n_st = S_IDLE;
            end else begin
              n_halt = 1'b0; adv = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else begin
      case (st_q)
        S_F0: if (mem_rvalid) begin
          n_buf = {mem_rdata[AW-1:2], 2'b00};
          n_st = S_F1;
        end
        S_F1: if (mem_rvalid) begin
          n_ioc = mem_rdata[31];
          n_cnt = mem_rdata[CW-1:0];
          if (mem_rdata[CW-1:0] == '0) begin
            if (cur_q == last_q) begin
              n_halt = 1'b1; n_st = S_IDLE;
            end else begin
              n_celv = 1'b0; adv = 1'b1;
            end
          end else n_st = S_XF;
        end
        S_XF: if (cnt_q == '0) begin
          n_celv = 1'b0;
          iset[1] = ioc_q;
          if (cur_q == last_q) begin
            iset[0] = 1'b1; n_halt = 1'b1; n_celv = 1'b1; n_st = S_IDLE;
          end else adv = 1'b1;
        end else if (smp_ready) begin
          n_cnt = cnt_q - CW'(1);
          n_buf = buf_q + AW'(2);
        end
        default: ;
      endcase
    end
    if (adv) begin
      n_cur = pre_q; n_pre = pre_q + IW'(1); n_st = S_F0;
    end
    n_ist = (ist_q & ~iclr) | iset | {fifo_err, 2'b00};
    n_irq = irq_q;
    if (n_ist != ist_q) begin
      if (n_ist == '0) n_irq = 1'b0;
      else if (|(n_ist & ien)) n_irq = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; base_q <= '0; buf_q <= '0; cur_q <= '0; last_q <= '0;
      pre_q <= '0; cnt_q <= '0; ctrl_q <= '0; halt_q <= 1'b1; celv_q <= 1'b0;
      ioc_q <= 1'b0; ist_q <= '0; irq_q <= 1'b0;
    end else begin
      st_q <= n_st; base_q <= n_base; buf_q <= n_buf; cur_q <= n_cur; last_q <= n_last;
      pre_q <= n_pre; cnt_q <= n_cnt; ctrl_q <= n_ctrl; halt_q <= n_halt; celv_q <= n_celv;
      ioc_q <= n_ioc; ist_q <= n_ist; irq_q <= n_irq;
    end
  end

  // R3
  halt_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !halt_q);
  // R9
  halt_nosmp_chk: assert property (@(posedge clk) disable iff (!rst_n) halt_q |-> !smp_valid);
  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R4
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_valid |-> !smp_addr[0]);
  // R6
  celv_halt_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(celv_q) |-> halt_q);
  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> (ist_q != '0));
  // R12
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (ist_q == '0) |-> !irq);
endmodule

// File: tb/sim_desc_ring_chan.sv
module sim_desc_ring_chan;
  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, mem_rvalid = 1'b0;
  logic        smp_ready = 1'b0, fifo_err = 1'b0, irq, mem_req, smp_valid, rdy_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_addr, mem_rdata, smp_addr, rv;
  logic [31:0] dadr [32];
  logic [31:0] dctl [32];
  logic [31:0] exp_q [$];
  int checks = 0, errors = 0, cyc = 0, popped = 0;
  localparam logic [31:0] BASE = 32'h1000;

  always #5 clk = ~clk;

  desc_ring_chan u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_addr(smp_addr), .fifo_err(fifo_err), .irq(irq));

  assign mem_rdata = mem_addr[2] ? dctl[5'((mem_addr - BASE) >> 3)] : dadr[5'((mem_addr - BASE) >> 3)];

  always @(posedge clk) mem_rvalid <= mem_req && !mem_rvalid;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_desc(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back({a[31:2], 2'b00} + 32'(2 * i));
  endtask

  always @(negedge clk) begin
    cyc++;
    smp_ready <= rdy_en && (cyc % 3 != 1);
    #2;
    if (smp_valid && smp_ready) begin
      // R4 no sample offered while a descriptor read is pending
      chk("R4 mem_req during sample", {31'd0, mem_req}, 32'd0);
      if (exp_q.size() == 0) chk("R4 unexpected sample", smp_addr, 32'hFFFFFFFF);
      else begin
        chk("R4 sample address", smp_addr, exp_q.pop_front());
        popped++;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 500; i++) begin
      rd(3'd2, rv);
      if (rv[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_fe();
    @(negedge clk); fifo_err = 1'b1;
    @(negedge clk); fifo_err = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin dadr[i] = '0; dctl[i] = '0; end
    dadr[0] = 32'h2001; dctl[0] = 32'h8000_0003;
    dadr[1] = 32'h3000; dctl[1] = 32'h0000_0002;
    dadr[2] = 32'h3800; dctl[2] = 32'h8000_0000;
    dadr[3] = 32'h4000; dctl[3] = 32'h8000_0001;
    dadr[4] = 32'h5000; dctl[4] = 32'h0000_0002;
    dadr[5] = 32'h6000; dctl[5] = 32'h0000_0004;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd2, rv); chk("R1 status", rv, 32'h01);
    rd(3'd1, rv); chk("R1 indices", rv, 32'h0);
    rd(3'd3, rv); chk("R1 control", rv, 32'h0);
    chk("R1 irq/mem_req", {30'd0, irq, mem_req}, 32'd0);
    // R2 base masking
    wr(3'd0, BASE | 32'h3);
    rd(3'd0, rv); chk("R2 base", rv, BASE);
    // R8 last-valid write while stopped only stores
    wr(3'd1, 32'd3);
    rd(3'd2, rv); chk("R8 still halted", rv, 32'h01);
    chk("R8 no fetch", {31'd0, mem_req}, 32'd0);
    // R3 start
    push_desc(32'h2001, 3); push_desc(32'h3000, 2); push_desc(32'h4000, 1);
    rdy_en = 1'b1;
    wr(3'd3, 32'h15);
    rd(3'd1, rv); chk("R3 indices after run", rv, 32'h0001_0300);
    rd(3'd2, rv); chk("R3 halted cleared", rv, 32'h00);
    chk("R3 fetch address", mem_addr, BASE);
    wait_halt();
    // R5 R6 R7 ring walk with skipped entry
    chk("R6 status at end", rv, 32'h0F);
    rd(3'd1, rv); chk("R5 indices at end", rv, 32'h0004_0303);
    rd(3'd4, rv); chk("R4 count zero", rv, 32'h0);
    chk("R7 samples delivered", popped, 32'd6);
    chk("R12 irq after completion", {31'd0, irq}, 32'd1);
    // R11 write-one-to-clear
    wr(3'd2, 32'h08);
    rd(3'd2, rv); chk("R11 clear bit3", rv, 32'h07);
    chk("R12 irq held by lv flag", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h03);
    rd(3'd2, rv); chk("R11 read-only bits", rv, 32'h07);
    wr(3'd2, 32'h04);
    rd(3'd2, rv); chk("R11 clear bit2", rv, 32'h03);
    chk("R12 irq drops", {31'd0, irq}, 32'd0);
    // R8 restart through last-valid
    push_desc(32'h5000, 2);
    wr(3'd1, 32'd36);
    rd(3'd2, rv); chk("R8 restart status", rv, 32'h00);
    rd(3'd1, rv); chk("R8 restart indices", rv, 32'h0005_0404);
    wait_halt();
    chk("R6 status after restart", rv, 32'h07);
    chk("R12 irq lv", {31'd0, irq}, 32'd1);
    chk("R8 samples delivered", popped, 32'd8);
    // R13 fifo error and its enable
    wr(3'd2, 32'h1C);
    chk("R12 irq cleared", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h00);
    pulse_fe();
    rd(3'd2, rv); chk("R13 fifo flag", rv, 32'h13);
    chk("R12 masked fifo irq", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'h10);
    wr(3'd3, 32'h08);
    pulse_fe();
    chk("R12 enabled fifo irq", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h10);
    chk("R12 fifo irq cleared", {31'd0, irq}, 32'd0);
    // R9 stop mid-buffer
    rdy_en = 1'b0;
    wr(3'd3, 32'h01);
    repeat (10) @(negedge clk);
    #1;
    chk("R4 offer at buffer start", smp_addr, 32'h6000);
    chk("R4 offer valid", {31'd0, smp_valid}, 32'd1);
    rd(3'd4, rv); chk("R4 count loaded", rv, 32'd4);
    wr(3'd3, 32'h00);
    rd(3'd2, rv); chk("R9 halted", rv, 32'h03);
    chk("R9 outputs idle", {30'd0, smp_valid, mem_req}, 32'd0);
    // R10 channel reset
    wr(3'd3, 32'h1C);
    wr(3'd3, 32'h02);
    rd(3'd3, rv); chk("R10 control kept", rv, 32'h1C);
    rd(3'd0, rv); chk("R10 base", rv, 32'h0);
    rd(3'd1, rv); chk("R10 indices", rv, 32'h0);
    rd(3'd4, rv); chk("R10 count", rv, 32'h0);
    rd(3'd2, rv); chk("R10 status", rv, 32'h01);
    // R7 empty descriptor at last-valid halts
    dctl[0] = 32'h8000_0000;
    wr(3'd0, BASE);
    wr(3'd1, 32'd0);
    wr(3'd3, 32'h01);
    wait_halt();
    chk("R7 halt on empty last", rv, 32'h01);
    rd(3'd1, rv); chk("R7 indices", rv, 32'h0001_0000);
    chk("R7 no irq", {31'd0, irq}, 32'd0);
    chk("R4 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule